// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM with a 16-bit data bus, split into byte lanes. The host hands over one word-sized read or write at a time. The controller then produces the RAM's control pins from registers:

- an active-low and an active-high chip select;
- an active-low output enable;
- an active-low write enable;
- one active-low enable per byte lane.

It holds each phase for a whole number of clock cycles, so that every minimum analogue interval is met. Each interval is given in nanoseconds as a parameter. The controller converts it to cycles by rounding up against `CLK_PERIOD_NS`.

The data bus is split into a driven value, a drive enable and a sampled input, and the pad tristate is built outside the block. Writes always end by raising write enable first. The write data is driven only after the RAM's release time has passed since write enable fell, and it stays driven until after write enable rises. Reads keep output enable low for the full read window. The bus is sampled on the edge that closes that window, and the lanes that were not selected are cleared.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is low and after it is released, both chip selects, output enable, write enable and every lane enable are inactive. The data drive enable is 0, `ready_o` is 1 and `done_o` is 0.
- R2: A request is taken only at a clock edge where `req_i` and `ready_o` are both high. `ready_o` is low for the whole time an operation is in progress, and a request raised in that time has no effect.
- R3: A read (`we_i`=0) holds both selects active, output enable low and write enable high for RD_CYC cycles. On the closing edge it samples the bus into `rdata_o`, clears every lane whose mask bit is 0 and raises output enable.
- R4: A write (`we_i`=1) holds write enable low for WL_CYC cycles. The bus is not driven for the first HZ_CYC of those cycles, then it is driven with a steady value until write enable rises. WL_CYC is never less than the pulse width, the address-to-end time, or HZ_CYC plus the data setup time.
- R5: Write enable is low only while both selects are active. The selects, the lane enables and the data drive stay active for HOLD_CYC cycles after write enable rises, and are released together after that.
- R6: Lane enable bit i is active low, and during an operation it is asserted exactly when mask bit i is 1. Lane 0 covers bits 7:0 and lane 1 covers bits 15:8. A write with an all-zero mask leaves the memory unchanged.
- R7: The controller never drives the bus while output enable is low. Output enable and write enable are never low together.
- R8: `done_o` is a single-cycle pulse, given once for each finished read or write. It comes in the first cycle in which `ready_o` is high again.
- R9: The address and lane enables do not change while the chip select is held active across consecutive cycles.
- R10: Cycle counts are ceil(ns/CLK_PERIOD_NS). At a 20 ns period, a read gives `done_o` 3 cycles after the accepting edge and a write gives it 4 cycles after, with write enable low for 3 of those cycles and data driven from the 2nd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| be_i | input | DW/8 | Lane mask, bit i selects bits 8i+7:8i |
| ready_o | output | 1 | Controller idle, request may be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Read data, unselected lanes zero |
| sram_addr_o | output | AW | RAM address |
| sram_sel_n_o | output | 1 | Active-low chip select |
| sram_sel_o | output | 1 | Active-high chip select |
| sram_oe_n_o | output | 1 | Active-low output enable |
| sram_we_n_o | output | 1 | Active-low write enable |
| sram_lane_n_o | output | DW/8 | Active-low lane enables |
| sram_dq_o | output | DW | Value driven onto the data bus |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | DW | Value sampled from the data bus |

## Verification
At a 20 ns clock the accepting edge is edge 0, and the pins change on the edges that follow it.

For a read, output enable is low from edge 0 up to edge 3. `rdata_o` and `done_o` update on edge 3.

For a write:
- write enable falls on edge 0;
- the drive begins on edge 1;
- write enable rises on edge 3;
- everything is released, with `done_o` raised, on edge 4.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accepting edge until `done_o` is seen, and checks the pin sequences at each of those falling edges against these edge numbers. The RAM model in the bench timestamps each pin edge and checks the analogue minimums and bus ownership directly.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_LOW,
    ST_WR_HOLD
  } state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 5,
  parameter int unsigned HZ_CYC   = 2,
  parameter int unsigned WL_CYC   = 5,
  parameter int unsigned HOLD_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  output logic ready_o,
  output logic accept_o,
  output logic drv_start_o,
  output logic we_end_o,
  output logic rd_last_o,
  output logic finish_o
);

  localparam int unsigned MAXC = max2(max2(RD_CYC, WL_CYC), HOLD_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1) + 1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [CW-1:0] RD_L    = CW'(RD_CYC);
  localparam logic [CW-1:0] HZ_L    = CW'(HZ_CYC);
  localparam logic [CW-1:0] WL_L    = CW'(WL_CYC);
  localparam logic [CW-1:0] HOLD_L  = CW'(HOLD_CYC);

  state_e          state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            wl_last, wr_last;

  assign ready_o     = (state_q == ST_IDLE);
  assign accept_o    = ready_o && req_i;
  assign rd_last_o   = (state_q == ST_RD) && (cnt_q == RD_L);
  assign drv_start_o = (state_q == ST_WR_LOW) && (cnt_q == HZ_L);
  assign wl_last     = (state_q == ST_WR_LOW) && (cnt_q == WL_L);
  assign wr_last     = (state_q == ST_WR_HOLD) && (cnt_q == HOLD_L);
  assign we_end_o    = wl_last;
  assign finish_o    = rd_last_o || wr_last;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_ONE;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = CNT_ONE;
        if (req_i) state_d = we_i ? ST_WR_LOW : ST_RD;
      end
      ST_RD: if (rd_last_o) state_d = ST_IDLE;
      ST_WR_LOW: if (wl_last) begin
        state_d = ST_WR_HOLD;
        cnt_d   = CNT_ONE;
      end
      ST_WR_HOLD: if (wr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins #(
  parameter int unsigned AW    = 18,
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_i,
  input  logic             drv_start_i,
  input  logic             we_end_i,
  input  logic             finish_i,
  output logic [AW-1:0]    addr_o,
  output logic             sel_o,
  output logic             oe_o,
  output logic             we_o,
  output logic [LANES-1:0] lane_o,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);

  // All pin state is registered so the RAM never sees decode glitches.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      sel_o   <= 1'b0;
      oe_o    <= 1'b0;
      we_o    <= 1'b0;
      lane_o  <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o <= addr_i;
        sel_o  <= 1'b1;
        oe_o   <= !we_i;
        we_o   <= we_i;
        lane_o <= be_i;
        if (we_i) dq_o <= wdata_i;
      end
      if (drv_start_i) dq_oe_o <= 1'b1;
      // write enable rises first; the rest follows on finish
      if (we_end_i) we_o <= 1'b0;
      if (finish_i) begin
        sel_o   <= 1'b0;
        oe_o    <= 1'b0;
        lane_o  <= '0;
        dq_oe_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sram_ctrl_rcap.sv
module sram_ctrl_rcap #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_last_i,
  input  logic             finish_i,
  input  logic [LANES-1:0] lane_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o
);

  logic [DW-1:0] lane_data;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_data[l*8 +: 8] = lane_i[l] ? dq_i[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (rd_last_i) rdata_o <= lane_data;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 18,
  parameter int unsigned DW            = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_RC_NS       = 45,
  parameter int unsigned T_AA_NS       = 45,
  parameter int unsigned T_DOE_NS      = 22,
  parameter int unsigned T_PWE_NS      = 35,
  parameter int unsigned T_AW_NS       = 35,
  parameter int unsigned T_WC_NS       = 45,
  parameter int unsigned T_SD_NS       = 25,
  parameter int unsigned T_HZ_NS       = 18,
  localparam int unsigned LANES        = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic [AW-1:0]    sram_addr_o,
  output logic             sram_sel_n_o,
  output logic             sram_sel_o,
  output logic             sram_oe_n_o,
  output logic             sram_we_n_o,
  output logic [LANES-1:0] sram_lane_n_o,
  output logic [DW-1:0]    sram_dq_o,
  output logic             sram_dq_oe_o,
  input  logic [DW-1:0]    sram_dq_i
);

  localparam int unsigned RD_CYC  = max2(max2(ns2cyc(T_RC_NS, CLK_PERIOD_NS),
                                              ns2cyc(T_AA_NS, CLK_PERIOD_NS)),
                                         max2(ns2cyc(T_DOE_NS, CLK_PERIOD_NS), 1));
  localparam int unsigned HZ_CYC  = max2(ns2cyc(T_HZ_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned SD_CYC  = max2(ns2cyc(T_SD_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned PWE_CYC = ns2cyc(T_PWE_NS, CLK_PERIOD_NS);
  localparam int unsigned AWE_CYC = ns2cyc(T_AW_NS, CLK_PERIOD_NS);
  localparam int unsigned WC_CYC  = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned WL_CYC  = max2(max2(PWE_CYC, AWE_CYC), HZ_CYC + SD_CYC);
  localparam int unsigned HOLD_CYC = (WC_CYC > WL_CYC) ? max2(WC_CYC - WL_CYC, 1) : 1;

  logic             accept, drv_start, we_end, rd_last, finish;
  logic             sel, oe, we;
  logic [LANES-1:0] lane;

  sram_ctrl_fsm #(
    .RD_CYC   (RD_CYC),
    .HZ_CYC   (HZ_CYC),
    .WL_CYC   (WL_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .ready_o     (ready_o),
    .accept_o    (accept),
    .drv_start_o (drv_start),
    .we_end_o    (we_end),
    .rd_last_o   (rd_last),
    .finish_o    (finish)
  );

  sram_ctrl_pins #(
    .AW    (AW),
    .DW    (DW),
    .LANES (LANES)
  ) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .be_i        (be_i),
    .drv_start_i (drv_start),
    .we_end_i    (we_end),
    .finish_i    (finish),
    .addr_o      (sram_addr_o),
    .sel_o       (sel),
    .oe_o        (oe),
    .we_o        (we),
    .lane_o      (lane),
    .dq_o        (sram_dq_o),
    .dq_oe_o     (sram_dq_oe_o)
  );

  sram_ctrl_rcap #(
    .DW    (DW),
    .LANES (LANES)
  ) u_rcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_last_i (rd_last),
    .finish_i  (finish),
    .lane_i    (lane),
    .dq_i      (sram_dq_i),
    .rdata_o   (rdata_o),
    .done_o    (done_o)
  );

  assign sram_sel_n_o  = !sel;
  assign sram_sel_o    = sel;
  assign sram_oe_n_o   = !oe;
  assign sram_we_n_o   = !we;
  assign sram_lane_n_o = ~lane;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned AW      = 18,
  parameter int unsigned DW      = 16,
  parameter int unsigned LANES   = DW / 8,
  parameter int unsigned RD_CYC  = 5,
  parameter int unsigned HZ_CYC  = 2,
  parameter int unsigned SD_CYC  = 3,
  parameter int unsigned PWE_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             done_o,
  input logic [AW-1:0]    sram_addr_o,
  input logic             sram_sel_n_o,
  input logic             sram_sel_o,
  input logic             sram_oe_n_o,
  input logic             sram_we_n_o,
  input logic [LANES-1:0] sram_lane_n_o,
  input logic [DW-1:0]    sram_dq_o,
  input logic             sram_dq_oe_o
);

  logic [7:0] we_low_cnt, drv_cnt, oe_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt <= '0;
      drv_cnt    <= '0;
      oe_low_cnt <= '0;
    end else begin
      we_low_cnt <= sram_we_n_o ? 8'd0 : ((we_low_cnt == 8'hff) ? we_low_cnt : we_low_cnt + 8'd1);
      drv_cnt    <= (sram_we_n_o || !sram_dq_oe_o) ? 8'd0 :
                    ((drv_cnt == 8'hff) ? drv_cnt : drv_cnt + 8'd1);
      oe_low_cnt <= sram_oe_n_o ? 8'd0 : ((oe_low_cnt == 8'hff) ? oe_low_cnt : oe_low_cnt + 8'd1);
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_sel_n_o && !sram_sel_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o));
  // R3
  rd_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_n_o) |-> (oe_low_cnt >= 8'(RD_CYC)) && done_o);
  // R4
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (we_low_cnt >= 8'(PWE_CYC)) && (drv_cnt >= 8'(SD_CYC)));
  // R4
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> we_low_cnt >= 8'(HZ_CYC));
  // R4
  wdata_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));
  // R5
  we_inside_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (!sram_sel_n_o && sram_sel_o));
  // R5
  hold_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (!sram_sel_n_o && sram_dq_oe_o));
  // R7
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);
  // R7
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> sram_oe_n_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_sel_n_o && !$past(sram_sel_n_o)) |-> ($stable(sram_addr_o) && $stable(sram_lane_n_o)));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .AW      (AW),
  .DW      (DW),
  .LANES   (LANES),
  .RD_CYC  (RD_CYC),
  .HZ_CYC  (HZ_CYC),
  .SD_CYC  (SD_CYC),
  .PWE_CYC (PWE_CYC)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ready_o       (ready_o),
  .done_o        (done_o),
  .sram_addr_o   (sram_addr_o),
  .sram_sel_n_o  (sram_sel_n_o),
  .sram_sel_o    (sram_sel_o),
  .sram_oe_n_o   (sram_oe_n_o),
  .sram_we_n_o   (sram_we_n_o),
  .sram_lane_n_o (sram_lane_n_o),
  .sram_dq_o     (sram_dq_o),
  .sram_dq_oe_o  (sram_dq_oe_o)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LN = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [LN-1:0] be = '0;
  logic          ready, done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] s_addr;
  logic          s_sel_n, s_sel, s_oe_n, s_we_n, s_dq_oe;
  logic [LN-1:0] s_lane_n;
  logic [DW-1:0] s_dq_o, s_dq_i;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sram_ctrl #(.AW(AW), .DW(DW), .CLK_PERIOD_NS(20)) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .sram_addr_o(s_addr), .sram_sel_n_o(s_sel_n), .sram_sel_o(s_sel),
    .sram_oe_n_o(s_oe_n), .sram_we_n_o(s_we_n), .sram_lane_n_o(s_lane_n),
    .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe), .sram_dq_i(s_dq_i)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [DW-1:0] mem [256];
  logic [DW-1:0] ref_mem [256];
  logic [DW-1:0] model_rd;
  realtime t_we_fall = 0, t_drv = 0, t_oe_fall = 0, t_oe_rise = 0;
  wire sel_on = !s_sel_n && s_sel;
  wire rd_en  = sel_on && !s_oe_n && s_we_n;

  always_comb begin
    for (int l = 0; l < LN; l++)
      model_rd[l*8 +: 8] = s_lane_n[l] ? 8'hEE : mem[s_addr][l*8 +: 8];
  end
  assign s_dq_i = rd_en ? model_rd : 16'h5A5A;

  always @(negedge s_we_n) t_we_fall = $realtime;
  always @(negedge s_oe_n) t_oe_fall = $realtime;
  always @(posedge s_oe_n) begin
    t_oe_rise = $realtime;
    if (rst_n) chk($realtime - t_oe_fall >= 45.0, "R3 read window ns",
                   32'($rtoi($realtime - t_oe_fall)), 32'd45);
  end
  always @(posedge s_dq_oe) begin
    t_drv = $realtime;
    if (rst_n) chk($realtime - t_we_fall >= 18.0 && $realtime - t_oe_rise >= 18.0,
                   "R4 turnaround ns", 32'($rtoi($realtime - t_we_fall)), 32'd18);
  end
  always @(posedge s_we_n) begin
    if (rst_n && sel_on) begin
      chk($realtime - t_we_fall >= 35.0, "R4 we pulse ns",
          32'($rtoi($realtime - t_we_fall)), 32'd35);
      chk(s_dq_oe && ($realtime - t_drv >= 25.0), "R4 data setup ns",
          32'($rtoi($realtime - t_drv)), 32'd25);
      for (int l = 0; l < LN; l++)
        if (!s_lane_n[l]) mem[s_addr][l*8 +: 8] = s_dq_o[l*8 +: 8];
    end
  end
  always @(negedge clk)
    if (rst_n && rd_en && s_dq_oe) chk(1'b0, "R7 bus contention", 32'd1, 32'd0);

  // ---------------- host helpers ----------------
  function automatic logic [DW-1:0] lane_mask(logic [LN-1:0] m);
    logic [DW-1:0] r;
    for (int l = 0; l < LN; l++) r[l*8 +: 8] = m[l] ? 8'hFF : 8'h00;
    return r;
  endfunction

  task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [LN-1:0] m, output logic [DW-1:0] rd, output int cyc);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = m;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    rd = rdata;
    if (w) ref_mem[a] = (ref_mem[a] & ~lane_mask(m)) | (d & lane_mask(m));
  endtask

  task automatic t_reset();
    chk(s_sel_n && !s_sel && s_oe_n && s_we_n && s_lane_n == 2'b11 && !s_dq_oe,
        "R1 pins idle in reset", {26'd0, s_sel_n, s_sel, s_oe_n, s_we_n, s_lane_n}, 32'h2F);
    chk(ready && !done, "R1 ready/done in reset", {30'd0, ready, done}, 32'd2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready && !done && s_we_n && s_oe_n && !s_dq_oe, "R1 idle after reset",
        {29'd0, ready, done, s_dq_oe}, 32'd4);
  endtask

  task automatic t_write_pins();
    int exp_we [5] = '{0, 0, 0, 1, 1};
    int exp_oe [5] = '{0, 1, 1, 1, 0};
    int exp_sl [5] = '{0, 0, 0, 0, 1};
    int exp_dn [5] = '{0, 0, 0, 0, 1};
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h05; wdata = 16'hA5C3; be = 2'b11;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (k > 0) @(negedge clk);
      chk(s_we_n == 1'(exp_we[k]), $sformatf("R10 write we_n s%0d", k), 32'(s_we_n), 32'(exp_we[k]));
      chk(s_dq_oe == 1'(exp_oe[k]), $sformatf("R4 write drive s%0d", k), 32'(s_dq_oe), 32'(exp_oe[k]));
      chk(s_sel_n == 1'(exp_sl[k]), $sformatf("R5 write select s%0d", k), 32'(s_sel_n), 32'(exp_sl[k]));
      chk(done == 1'(exp_dn[k]), $sformatf("R8 write done s%0d", k), 32'(done), 32'(exp_dn[k]));
      if (k < 4) chk(s_lane_n == 2'b00 && s_oe_n && s_addr == 8'h05 && s_dq_o == 16'hA5C3,
                     $sformatf("R9 write addr/lanes s%0d", k), {14'd0, s_lane_n, s_addr, 8'd0}, 32'h0500);
    end
    ref_mem[8'h05] = 16'hA5C3;
  endtask

  task automatic t_read_pins();
    int exp_oe [4] = '{0, 0, 0, 1};
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h05; be = 2'b01;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      chk(s_oe_n == 1'(exp_oe[k]), $sformatf("R3 read oe_n s%0d", k), 32'(s_oe_n), 32'(exp_oe[k]));
      chk(done == (k == 3), $sformatf("R10 read done s%0d", k), 32'(done), 32'(k == 3));
      if (k < 3) chk(s_lane_n == 2'b10 && s_we_n, $sformatf("R6 read lane enables s%0d", k),
                     32'(s_lane_n), 32'h2);
    end
    chk(rdata == 16'h00C3, "R3 read lane clear", 32'(rdata), 32'h00C3);
    chk(ready, "R8 ready with done", 32'(ready), 32'd1);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] rd;
    int cyc;
    do_op(1'b1, 8'h10, 16'h1234, 2'b11, rd, cyc);
    chk(cyc == 4, "R10 write latency", 32'(cyc), 32'd4);
    do_op(1'b1, 8'h10, 16'hFF00, 2'b10, rd, cyc);
    do_op(1'b0, 8'h10, 16'h0, 2'b11, rd, cyc);
    chk(cyc == 3, "R10 read latency", 32'(cyc), 32'd3);
    chk(rd == 16'hFF34, "R6 high lane write", 32'(rd), 32'hFF34);
    do_op(1'b1, 8'h10, 16'h00AB, 2'b01, rd, cyc);
    do_op(1'b0, 8'h10, 16'h0, 2'b10, rd, cyc);
    chk(rd == 16'hFF00, "R6 low lane write keeps high", 32'(rd), 32'hFF00);
    do_op(1'b1, 8'h10, 16'hDEAD, 2'b00, rd, cyc);
    do_op(1'b0, 8'h10, 16'h0, 2'b11, rd, cyc);
    chk(rd == 16'hFFAB, "R6 zero mask write ignored", 32'(rd), 32'hFFAB);
  endtask

  task automatic t_busy_ignore();
    logic [DW-1:0] rd;
    int cyc;
    int extra = 0;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h20; be = 2'b11;
    @(posedge clk);
    @(negedge clk);
    chk(!ready, "R2 ready low while busy", 32'(ready), 32'd0);
    we = 1'b1; wdata = 16'hBEEF; addr = 8'h21;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(done, "R2 read finishes", 32'(done), 32'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || !s_we_n) extra++;
    end
    chk(extra == 0, "R2 busy request ignored", 32'(extra), 32'd0);
    do_op(1'b0, 8'h21, 16'h0, 2'b11, rd, cyc);
    chk(rd == ref_mem[8'h21], "R2 memory untouched", 32'(rd), 32'(ref_mem[8'h21]));
  endtask

  task automatic t_random();
    logic [DW-1:0] rd;
    int cyc;
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 15));
      logic [LN-1:0] m = LN'($urandom);
      logic w = 1'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      logic [DW-1:0] exp = ref_mem[a] & lane_mask(m);
      do_op(w, a, d, m, rd, cyc);
      if (!w && rd != exp) begin
        bad++;
        $display("FAIL R3 random read @%h: actual %h expected %h", a, rd, exp);
      end
      if (cyc != (w ? 4 : 3)) begin
        bad++;
        $display("FAIL R10 random latency: actual %0d expected %0d", cyc, w ? 4 : 3);
      end
    end
    chk(bad == 0, "R3 R6 random back-to-back", 32'(bad), 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h0000;
      ref_mem[i] = 16'h0000;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_write_pins();
    t_read_pins();
    t_lanes();
    t_busy_ignore();
    t_random();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

endmodule